// File: doc/BRIEF.md
# Deterministic Reset Deassertion Aligner

This block makes hard-reset release happen at the same clock phase on every power-up, in every chip that shares a clock reference. A free-running modulo-8 phase counter starts when power-good goes high. An asynchronous reset request enters through a two-stage synchronizer and is captured only at one fixed phase. The captured value then becomes a registered reset-out request at a second fixed phase. The internal hard reset follows reset-out at a third fixed phase. Because every chip uses the same three phases, reset is released in each chip with a fixed, repeatable relationship to the others.

The block also recognises the first hard-reset release after power-good. At that release it gives a one-cycle pulse that clears sticky configuration state. Those sticky registers are outside the block. A mask output stays high through the whole reset sequence, so the sticky state cannot latch invalid values while the sequence runs.

Top module: `rst_phase_aligner`

## Requirements
- R1: `phase` increments by one on every clock and wraps from 7 to 0. It is held at 0 while `pwr_ok` is low.
- R2: While `pwr_ok` is low, `rst_out` and `hard_rst` are 1 and `sticky_clr` is 0. The first-release history is also forgotten.
- R3: `rst_req_in` (1 = reset requested) passes through a 2-flop synchronizer. Its synchronized value is captured only at the clock edge where `phase` reads 6.
- R4: If `rst_req_in` is high for even one clock, at any phase, the request is held. The next capture at phase 6 then sees 1.
- R5: `rst_out` loads the captured value only at the edge where `phase` reads 0, so a change is first visible when `phase` reads 1. At every other edge it holds its value.
- R6: `hard_rst` loads `rst_out` only at the edge where `phase` reads 1, so a change is first visible when `phase` reads 2. At every other edge it holds its value.
- R7: `sticky_clr` is a single-cycle pulse. It is high in the first cycle that `hard_rst` is low after `pwr_ok` rose. Later releases of `hard_rst` give no pulse until `pwr_ok` has been low again.
- R8: `sticky_mask` is 1 whenever `rst_out` or `hard_rst` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common reference clock |
| pwr_ok | input | 1 | Power-good. Low resets the block asynchronously |
| rst_req_in | input | 1 | Asynchronous reset request, active high |
| phase | output | PHASE_W | Current value of the modulo-8 phase counter |
| rst_out | output | 1 | Registered reset-out request to other chips, active high |
| hard_rst | output | 1 | Internal hard reset, active high |
| sticky_clr | output | 1 | One-cycle clear pulse at the first release after power-good |
| sticky_mask | output | 1 | High while the reset sequence is in progress |

## Verification
The hardest case to reach is a reset request of a single clock that falls between two capture points. Only the hold path can keep such a request alive until phase 6. The bench waits for each of the eight phase values in turn and pulses `rst_req_in` for one cycle there. It checks that every pulse yields exactly one reassert and release of `rst_out` and `hard_rst`, with no further `sticky_clr`. A second power-good cycle then shows that the first-release pulse is armed again.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

   // one-hot style strobes decoded from the phase counter
   typedef struct packed {
      logic smp;   // capture synchronized request
      logic drv;   // update reset-out
      logic rel;   // update hard reset
   } rpa_strobe_t;

   function automatic int unsigned rpa_mod(input int unsigned w);
      return 32'd1 << w;
   endfunction

endpackage

// File: rtl/rpa_phase_ctr.sv
module rpa_phase_ctr
   import rpa_pkg::*;
#(
   parameter int unsigned PHASE_W    = 3,
   parameter int unsigned SAMPLE_PH  = 6,
   parameter int unsigned DRIVE_PH   = 0,
   parameter int unsigned RELEASE_PH = 1
) (
   input  logic               clk,
   input  logic               pwr_ok,
   output logic [PHASE_W-1:0] phase,
   output rpa_strobe_t        strb
);
   localparam logic [PHASE_W-1:0] PH_LAST = '1;
   localparam logic [PHASE_W-1:0] PH_SMP  = PHASE_W'(SAMPLE_PH);
   localparam logic [PHASE_W-1:0] PH_DRV  = PHASE_W'(DRIVE_PH);
   localparam logic [PHASE_W-1:0] PH_REL  = PHASE_W'(RELEASE_PH);

   logic [PHASE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge pwr_ok) begin
      if (!pwr_ok) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
   end

   assign phase    = cnt_q;
   assign strb.smp = (cnt_q == PH_SMP);
   assign strb.drv = (cnt_q == PH_DRV);
   assign strb.rel = (cnt_q == PH_REL);

   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!pwr_ok)
      (cnt_q == PH_LAST) |=> (cnt_q == '0));                          // R1
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!pwr_ok)
      (cnt_q != PH_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));         // R1
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!pwr_ok)
      $onehot0({strb.smp, strb.drv, strb.rel}));                      // R1
endmodule

// File: rtl/rpa_sync.sv
module rpa_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic pwr_ok,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge pwr_ok) begin
            if (!pwr_ok) chain_q <= RST_VAL;
            else         chain_q <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge pwr_ok) begin
            if (!pwr_ok) chain_q <= {STAGES{RST_VAL}};
            else         chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rpa_capture.sv
module rpa_capture #(
   parameter bit HOLD_PULSES = 1'b1
) (
   input  logic clk,
   input  logic pwr_ok,
   input  logic sync_q,
   input  logic smp_stb,
   output logic smp_q
);
   generate
      if (HOLD_PULSES) begin : g_hold
         logic pend_q;
         always_ff @(posedge clk or negedge pwr_ok) begin
            if (!pwr_ok) begin
               pend_q <= 1'b0;
               smp_q  <= 1'b1;
            end else if (smp_stb) begin
               pend_q <= 1'b0;
               smp_q  <= sync_q | pend_q;
            end else begin
               pend_q <= pend_q | sync_q;
            end
         end

         AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!pwr_ok)
            (sync_q && !smp_stb) |=> pend_q);                         // R4
         AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!pwr_ok)
            (pend_q && smp_stb) |=> smp_q);                           // R4
      end else begin : g_plain
         always_ff @(posedge clk or negedge pwr_ok) begin
            if (!pwr_ok)      smp_q <= 1'b1;
            else if (smp_stb) smp_q <= sync_q;
         end
      end
   endgenerate

   AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!pwr_ok)
      !smp_stb |=> $stable(smp_q));                                   // R3
endmodule

// File: rtl/rpa_sequencer.sv
module rpa_sequencer (
   input  logic clk,
   input  logic pwr_ok,
   input  logic smp_q,
   input  logic drv_stb,
   input  logic rel_stb,
   output logic rst_out,
   output logic hard_rst,
   output logic sticky_clr,
   output logic sticky_mask
);
   logic out_q, hard_q, clr_q, first_done_q;

   always_ff @(posedge clk or negedge pwr_ok) begin
      if (!pwr_ok) begin
         out_q        <= 1'b1;
         hard_q       <= 1'b1;
         clr_q        <= 1'b0;
         first_done_q <= 1'b0;
      end else begin
         clr_q <= 1'b0;
         if (drv_stb) out_q <= smp_q;
         if (rel_stb) begin
            hard_q <= out_q;
            if (hard_q && !out_q && !first_done_q) begin
               clr_q        <= 1'b1;
               first_done_q <= 1'b1;
            end
         end
      end
   end

   assign rst_out     = out_q;
   assign hard_rst    = hard_q;
   assign sticky_clr  = clr_q;
   assign sticky_mask = out_q | hard_q;

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!pwr_ok)
      !drv_stb |=> $stable(out_q));                                   // R5
   AST_HARD_HOLD: assert property (@(posedge clk) disable iff (!pwr_ok)
      !rel_stb |=> $stable(hard_q));                                  // R6
   AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!pwr_ok)
      clr_q |=> !clr_q);                                              // R7
   AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (!pwr_ok)
      clr_q |-> ($fell(hard_q) && !out_q));                           // R7
endmodule

// File: rtl/rst_phase_aligner.sv
module rst_phase_aligner
   import rpa_pkg::*;
#(
   parameter int unsigned PHASE_W     = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SAMPLE_PH   = 6,
   parameter int unsigned DRIVE_PH    = 0,
   parameter int unsigned RELEASE_PH  = 1,
   parameter bit          HOLD_PULSES = 1'b1
) (
   input  logic               clk,
   input  logic               pwr_ok,
   input  logic               rst_req_in,
   output logic [PHASE_W-1:0] phase,
   output logic               rst_out,
   output logic               hard_rst,
   output logic               sticky_clr,
   output logic               sticky_mask
);
   localparam int unsigned PH_MOD = rpa_mod(PHASE_W);

   generate
      if (PHASE_W < 2 || PHASE_W > 8) begin : g_bad_w
         $error("PHASE_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SAMPLE_PH >= PH_MOD || DRIVE_PH >= PH_MOD || RELEASE_PH >= PH_MOD) begin : g_bad_ph
         $error("phase point beyond counter modulus");
      end
      if (SAMPLE_PH == DRIVE_PH || SAMPLE_PH == RELEASE_PH || DRIVE_PH == RELEASE_PH) begin : g_dup_ph
         $error("phase points must differ");
      end
   endgenerate

   rpa_strobe_t strb;
   logic        sync_q;
   logic        smp_q;

   rpa_phase_ctr #(
      .PHASE_W(PHASE_W), .SAMPLE_PH(SAMPLE_PH),
      .DRIVE_PH(DRIVE_PH), .RELEASE_PH(RELEASE_PH)
   ) u_ctr (
      .clk(clk), .pwr_ok(pwr_ok), .phase(phase), .strb(strb)
   );

   rpa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .pwr_ok(pwr_ok), .d(rst_req_in), .q(sync_q)
   );

   rpa_capture #(.HOLD_PULSES(HOLD_PULSES)) u_cap (
      .clk(clk), .pwr_ok(pwr_ok), .sync_q(sync_q),
      .smp_stb(strb.smp), .smp_q(smp_q)
   );

   rpa_sequencer u_seq (
      .clk(clk), .pwr_ok(pwr_ok), .smp_q(smp_q),
      .drv_stb(strb.drv), .rel_stb(strb.rel),
      .rst_out(rst_out), .hard_rst(hard_rst),
      .sticky_clr(sticky_clr), .sticky_mask(sticky_mask)
   );

   AST_RST_SEQ: assert property (@(posedge clk) disable iff (!pwr_ok)
      $fell(hard_rst) |-> !rst_out);                                  // R6
endmodule

// File: tb/sim_rst_phase_aligner.sv
module sim_rst_phase_aligner;
   logic       clk = 1'b0;
   logic       pwr_ok = 1'b0;
   logic       rst_req_in = 1'b1;
   logic [2:0] phase;
   logic       rst_out, hard_rst, sticky_clr, sticky_mask;

   int total = 0;
   int bad   = 0;
   int clr_seen = 0;
   int out_rises = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rst_phase_aligner u0 (
      .clk(clk), .pwr_ok(pwr_ok), .rst_req_in(rst_req_in),
      .phase(phase), .rst_out(rst_out), .hard_rst(hard_rst),
      .sticky_clr(sticky_clr), .sticky_mask(sticky_mask)
   );

   // behavioural reference model
   int  m_ph;
   bit  m_s1, m_s2, m_pend, m_smp, m_out, m_hard, m_clr, m_first;
   bit  m_prev_out;

   always @(posedge clk or negedge pwr_ok) begin
      if (!pwr_ok) begin
         m_ph = 0; m_s1 = 1; m_s2 = 1; m_pend = 0; m_smp = 1;
         m_out = 1; m_hard = 1; m_clr = 0; m_first = 0;
      end else begin
         int  ph0;
         bit  s1o, s2o, pendo, smpo, outo, hardo, firsto;
         ph0 = m_ph; s1o = m_s1; s2o = m_s2; pendo = m_pend; smpo = m_smp;
         outo = m_out; hardo = m_hard; firsto = m_first;
         m_ph = (ph0 + 1) % 8;
         m_s1 = rst_req_in;
         m_s2 = s1o;
         if (ph0 == 6) begin
            m_smp = s2o | pendo; m_pend = 0;
         end else begin
            m_pend = pendo | s2o;
         end
         if (ph0 == 0) m_out = smpo;
         m_clr = 0;
         if (ph0 == 1) begin
            m_hard = outo;
            if (hardo && !outo && !firsto) begin
               m_clr = 1; m_first = 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare on every falling edge, before stimulus moves
   always @(negedge clk) begin
      if (!done) begin
         chk("R1 phase",       phase,       m_ph);
         chk("R5 rst_out",     rst_out,     m_out);
         chk("R6 hard_rst",    hard_rst,    m_hard);
         chk("R7 sticky_clr",  sticky_clr,  m_clr);
         chk("R8 sticky_mask", sticky_mask, m_out | m_hard);
         if (sticky_clr) clr_seen++;
         if (rst_out && !m_prev_out) out_rises++;
         m_prev_out = rst_out;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic wait_phase(input int p);
      @(negedge clk);
      while (phase != 3'(p)) @(negedge clk);
      #1;
   endtask

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int lfsr;
      int rises0;
      m_prev_out = 1'b1;
      step(5);
      // R2: reset state with power-good low
      chk("R2 reset rst_out", rst_out, 1);
      chk("R2 reset hard_rst", hard_rst, 1);
      chk("R2 reset sticky_clr", sticky_clr, 0);
      chk("R1 reset phase", phase, 0);

      pwr_ok = 1'b1;
      step(20);
      // R3: request still high, nothing released
      chk("R3 held while requested", hard_rst, 1);
      rst_req_in = 1'b0;
      step(24);
      chk("R7 first release pulse count", clr_seen, 1);
      chk("R6 released", hard_rst, 0);
      chk("R8 mask low after release", sticky_mask, 0);

      // R4: one-cycle pulse at every phase value
      for (int p = 0; p < 8; p++) begin
         rises0 = out_rises;
         wait_phase(p);
         rst_req_in = 1'b1;
         step(1);
         rst_req_in = 1'b0;
         step(30);
         chk("R4 short pulse captured", out_rises - rises0, 1);
         chk("R6 released after pulse", hard_rst, 0);
      end
      chk("R7 no pulse on later releases", clr_seen, 1);

      // R3: pseudo-random request pattern
      lfsr = 32'h1ace;
      for (int i = 0; i < 400; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
         rst_req_in = ((lfsr & 7) == 0);
         step(1);
      end
      rst_req_in = 1'b0;
      step(30);
      chk("R3 quiet after random", hard_rst, 0);

      // R2/R7: power cycle re-arms the first-release pulse
      pwr_ok = 1'b0;
      step(3);
      chk("R2 reset again", rst_out & hard_rst, 1);
      pwr_ok = 1'b1;
      step(30);
      chk("R7 pulse after power cycle", clr_seen, 2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule